// File: doc/BRIEF.md
# Power-Management I2C Register Target

This block is an I2C target that answers at one fixed 7-bit bus address and holds a small byte-wide register space used for power control. It samples the bus lines with the system clock and detects START, STOP and clock edges from those samples. It acknowledges its own address and shifts bytes in and out. It drives SDA only low, and `sda_oe` is the enable for the open-drain pull-down.

In a write, the first data byte sets an internal register pointer. Each byte after it is written to the register the pointer selects, and the pointer then moves to the next index. In a read, bytes are returned starting at the pointer, and the pointer also advances after each byte.

Three indexes have a meaning:
- A camera-select register takes only the values 1 and 2.
- Two reset registers act as an ordered pair. Setting the first to 1 arms the pair. Setting the second to 1 while the pair is armed gives a one-clock power-cycle request on `pwr_cycle_req`, which the power sequencer outside this block acts on.

Top module: `pmi_power_target`

## Requirements
- R1: After reset, `sda_oe` is 0, `pwr_cycle_req` is 0 and `cam_sel` equals 0x01.
- R2: An address byte holding 7-bit address 0x04 (bits 7..1, with R/W in bit 0, where 1 means read) is acknowledged by driving SDA low during the ninth clock. Any other address gets no acknowledge, and `sda_oe` stays 0 for the rest of that transaction. `sda_oe` changes only while the sampled SCL is low.
- R3: In a write, the first data byte loads the register pointer. Each following byte writes the pointed register, after which the pointer increments by one. Every data byte is acknowledged.
- R4: Writing 0x01 to index 0x70 and then writing 0x01 to index 0x11 raises `pwr_cycle_req` for exactly one clock.
- R5: Writing 0x01 to index 0x11 while index 0x70 is not armed gives no request. This includes the reverse order: 0x11 first, then 0x70.
- R6: Writing any value other than 0x01 to index 0x70 clears the arm, so a later 0x01 to index 0x11 gives no request.
- R7: After a request, indexes 0x70 and 0x11 both read back 0x00.
- R8: Index 0x31 accepts 0x01 or 0x02, and `cam_sel` shows the stored value. Other values are acknowledged but leave the register unchanged.
- R9: A read returns the pointed register and increments the pointer after each byte. Indexes with no register read 0x00. The target releases SDA after the master's NACK.
- R10: Index 0x70 reads 0x01 while armed and 0x00 otherwise. Index 0x11 always reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as received |
| sda_i | input | 1 | I2C data line as received |
| sda_oe | output | 1 | When 1, pull SDA low |
| cam_sel | output | 8 | Current camera-select register value |
| pwr_cycle_req | output | 1 | One-clock power-cycle request |

## Verification
The checker enforces these rules on every clock:
- The power-cycle request never lasts more than one clock.
- A request only comes from an armed state, and the arm is cleared when it fires.
- `cam_sel` only ever holds a legal code.
- SDA is only moved while SCL is low.

Only the bench scenarios can show the rest:
- The order in which the reset writes arrive, the arm being cleared by a non-one value, and a rejected camera value.
- Pointer auto-increment across bytes, and reads of unused indexes.
- Silence towards a foreign address.

These are compared against a behavioural register model in the bench.

// File: rtl/pmi_pkg.sv
package pmi_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK
   } pmi_state_e;

   typedef struct packed {
      logic       vld;
      logic [7:0] idx;
      logic [7:0] dat;
   } pmi_wr_t;
endpackage

// File: rtl/pmi_line_sync.sv
module pmi_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int MSB = SYNC_STAGES - 1;

   logic [MSB:0] scl_sr, sda_sr;
   logic         scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sr <= '1;
         sda_sr <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_sr <= {scl_sr[MSB-1:0], scl_i};
         sda_sr <= {sda_sr[MSB-1:0], sda_i};
         scl_q  <= scl_sr[MSB];
         sda_q  <= sda_sr[MSB];
      end
   end

   assign scl_s     = scl_sr[MSB];
   assign sda_s     = sda_sr[MSB];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/pmi_target_fsm.sv
module pmi_target_fsm
   import pmi_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h04
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_s,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic [7:0] rd_data,
   output logic [7:0] ptr,
   output pmi_wr_t    wr_o,
   output logic       sda_oe
);
   pmi_state_e st;
   logic [3:0] cnt;
   logic [7:0] sh, tx;
   logic       rw, first, nack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         sh     <= '0;
         tx     <= '0;
         rw     <= 1'b0;
         first  <= 1'b0;
         nack   <= 1'b0;
         ptr    <= '0;
         wr_o   <= '0;
         sda_oe <= 1'b0;
      end else begin
         wr_o.vld <= 1'b0;
         if (start_det) begin
            st     <= ST_ADDR;
            cnt    <= '0;
            first  <= 1'b1;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_WR: begin
                  if (scl_rise) begin
                     sh  <= {sh[6:0], sda_s};
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     cnt <= '0;
                     if (st == ST_ADDR) begin
                        if (sh[7:1] == DEV_ADDR) begin
                           rw     <= sh[0];
                           sda_oe <= 1'b1;
                           st     <= ST_ADDR_ACK;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else begin
                        sda_oe <= 1'b1;
                        st     <= ST_WR_ACK;
                        if (first) begin
                           ptr   <= sh;
                           first <= 1'b0;
                        end else begin
                           wr_o <= '{vld: 1'b1, idx: ptr, dat: sh};
                           ptr  <= ptr + 8'd1;
                        end
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (rw) begin
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        ptr    <= ptr + 8'd1;
                        cnt    <= '0;
                        st     <= ST_RD;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_WR;
                     end
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     st     <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_fall) begin
                     if (cnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        st     <= ST_RD_ACK;
                     end else begin
                        tx     <= {tx[6:0], 1'b0};
                        sda_oe <= ~tx[6];
                        cnt    <= cnt + 4'd1;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     nack <= sda_s;
                  end else if (scl_fall) begin
                     if (nack) begin
                        st <= ST_IDLE;
                     end else begin
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        ptr    <= ptr + 8'd1;
                        cnt    <= '0;
                        st     <= ST_RD;
                     end
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/pmi_regfile.sv
module pmi_regfile
   import pmi_pkg::*;
#(
   parameter logic [7:0] IDX_RST1  = 8'h70,
   parameter logic [7:0] IDX_RST2  = 8'h11,
   parameter logic [7:0] IDX_CAM   = 8'h31,
   parameter logic [7:0] CAM_RESET = 8'h01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  pmi_wr_t    wr_i,
   input  logic [7:0] rd_idx,
   output logic [7:0] rd_data,
   output logic [7:0] cam_sel,
   output logic       armed,
   output logic       req
);
   localparam logic [7:0] ONE = 8'h01;
   localparam logic [7:0] TWO = 8'h02;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         req     <= 1'b0;
         cam_sel <= CAM_RESET;
      end else begin
         req <= 1'b0;
         if (wr_i.vld) begin
            if (wr_i.idx == IDX_RST1) begin
               armed <= (wr_i.dat == ONE);
            end else if (wr_i.idx == IDX_RST2) begin
               if (wr_i.dat == ONE && armed) begin
                  req   <= 1'b1;
                  armed <= 1'b0;
               end
            end else if (wr_i.idx == IDX_CAM) begin
               if (wr_i.dat == ONE || wr_i.dat == TWO) cam_sel <= wr_i.dat;
            end
         end
      end
   end

   always_comb begin
      if (rd_idx == IDX_RST1)     rd_data = {7'd0, armed};
      else if (rd_idx == IDX_CAM) rd_data = cam_sel;
      else                        rd_data = 8'h00;
   end
endmodule

// File: rtl/pmi_power_target.sv
module pmi_power_target
   import pmi_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h04,
   parameter logic [7:0] IDX_RST1    = 8'h70,
   parameter logic [7:0] IDX_RST2    = 8'h11,
   parameter logic [7:0] IDX_CAM     = 8'h31,
   parameter logic [7:0] CAM_RESET   = 8'h01,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   output logic [7:0] cam_sel,
   output logic       pwr_cycle_req
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (IDX_RST1 == IDX_RST2 || IDX_RST1 == IDX_CAM || IDX_RST2 == IDX_CAM) begin : g_bad_idx
      $error("register indexes must differ");
   end
   if (CAM_RESET != 8'h01 && CAM_RESET != 8'h02) begin : g_bad_cam
      $error("CAM_RESET must be 1 or 2");
   end

   logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [7:0] ptr, rd_data;
   logic       rst1_armed;
   pmi_wr_t    wr;

   pmi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   pmi_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rd_data   (rd_data),
      .ptr       (ptr),
      .wr_o      (wr),
      .sda_oe    (sda_oe)
   );

   pmi_regfile #(
      .IDX_RST1  (IDX_RST1),
      .IDX_RST2  (IDX_RST2),
      .IDX_CAM   (IDX_CAM),
      .CAM_RESET (CAM_RESET)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr),
      .rd_idx  (ptr),
      .rd_data (rd_data),
      .cam_sel (cam_sel),
      .armed   (rst1_armed),
      .req     (pwr_cycle_req)
   );
endmodule

// File: rtl/pmi_power_target_chk.sv
module pmi_power_target_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       sda_oe,
   input logic [7:0] cam_sel,
   input logic       pwr_cycle_req,
   input logic       rst1_armed
);
   p_req_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_cycle_req |=> !pwr_cycle_req);

   p_req_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_cycle_req |-> $past(rst1_armed));

   p_disarm_on_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_cycle_req |-> !rst1_armed);

   p_cam_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cam_sel == 8'h01) || (cam_sel == 8'h02));

   p_oe_moves_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !$past(scl_s));
endmodule

bind pmi_power_target pmi_power_target_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .scl_s         (scl_s),
   .sda_oe        (sda_oe),
   .cam_sel       (cam_sel),
   .pwr_cycle_req (pwr_cycle_req),
   .rst1_armed    (rst1_armed)
);

// File: tb/sim_pmi_power_target.sv
module sim_pmi_power_target;
   localparam int CLK_PERIOD = 10;
   localparam int Q = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe, pwr_cycle_req;
   logic [7:0] cam_sel;
   logic sda_line;

   assign sda_line = sda_m & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmi_power_target u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (scl_m),
      .sda_i         (sda_line),
      .sda_oe        (sda_oe),
      .cam_sel       (cam_sel),
      .pwr_cycle_req (pwr_cycle_req)
   );

   int n_run = 0, n_fail = 0;
   int seen_pulses = 0, m_pulses = 0;
   logic [7:0] m_cam = 8'h01;
   bit m_arm = 1'b0;
   bit bus_idle = 1'b0;
   bit watch_quiet = 1'b0, oe_seen = 1'b0;
   bit prev_req = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         if (pwr_cycle_req) seen_pulses++;
         if (pwr_cycle_req && prev_req) chk(0, "R4 request wider than one clock", 2, 1);
         prev_req = pwr_cycle_req;
         if (bus_idle) chk(cam_sel == m_cam, "R8 cam_sel vs model", cam_sel, m_cam);
         if (watch_quiet && sda_oe) oe_seen = 1'b1;
      end
   end

   task automatic qwait();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; qwait();
      scl_m = 1'b1; qwait();
      sda_m = 1'b0; qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; qwait();
      scl_m = 1'b1; qwait();
      sda_m = 1'b1; qwait();
   endtask

   task automatic put_bit(input bit b);
      sda_m = b; qwait();
      scl_m = 1'b1; qwait(); qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic get_bit(output bit b);
      sda_m = 1'b1; qwait();
      scl_m = 1'b1; qwait();
      b = sda_line; qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic put_byte(input logic [7:0] d, output bit ack);
      bit b;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(b);
      ack = !b;
   endtask

   task automatic get_byte(output logic [7:0] d, input bit last);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
      put_bit(last);
   endtask

   function automatic logic [7:0] model_read(input logic [7:0] idx);
      if (idx == 8'h70) return {7'd0, m_arm};
      if (idx == 8'h31) return m_cam;
      return 8'h00;
   endfunction

   task automatic model_write(input logic [7:0] idx, input logic [7:0] v);
      if (idx == 8'h70) m_arm = (v == 8'h01);
      else if (idx == 8'h11) begin
         if (v == 8'h01 && m_arm) begin
            m_pulses++;
            m_arm = 1'b0;
         end
      end else if (idx == 8'h31 && (v == 8'h01 || v == 8'h02)) m_cam = v;
   endtask

   task automatic end_txn();
      bus_stop();
      qwait();
      bus_idle = 1'b1;
   endtask

   // write n bytes (1..2) starting at idx
   task automatic wr_txn(input logic [7:0] idx, input logic [7:0] d0, input logic [7:0] d1,
                         input int n, input string tag);
      bit ack;
      bus_idle = 1'b0;
      bus_start();
      put_byte({7'h04, 1'b0}, ack);
      chk(ack, "R2 address 0x04 acked", ack, 1);
      put_byte(idx, ack);
      chk(ack, "R3 pointer byte acked", ack, 1);
      put_byte(d0, ack);
      chk(ack, {tag, " R3 data byte acked"}, ack, 1);
      model_write(idx, d0);
      if (n > 1) begin
         put_byte(d1, ack);
         chk(ack, {tag, " R3 second data byte acked"}, ack, 1);
         model_write(idx + 8'd1, d1);
      end
      end_txn();
      chk(seen_pulses == m_pulses, {tag, " request count"}, seen_pulses, m_pulses);
   endtask

   task automatic rd_txn(input logic [7:0] idx, input int n, input string tag);
      bit ack;
      logic [7:0] d;
      bus_idle = 1'b0;
      bus_start();
      put_byte({7'h04, 1'b0}, ack);
      put_byte(idx, ack);
      chk(ack, "R3 pointer byte acked", ack, 1);
      bus_start();
      put_byte({7'h04, 1'b1}, ack);
      chk(ack, "R2 read address acked", ack, 1);
      for (int k = 0; k < n; k++) begin
         get_byte(d, k == n - 1);
         chk(d == model_read(idx + 8'(k)), tag, d, model_read(idx + 8'(k)));
      end
      chk(!sda_oe, "R9 SDA released after NACK", sda_oe, 0);
      end_txn();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      bit ack;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(sda_oe == 1'b0, "R1 sda_oe at reset", sda_oe, 0);
      chk(pwr_cycle_req == 1'b0, "R1 request at reset", pwr_cycle_req, 0);
      chk(cam_sel == 8'h01, "R1 cam_sel at reset", cam_sel, 8'h01);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      bus_idle = 1'b1;

      // R2 foreign address: no ack, SDA never driven
      bus_idle = 1'b0;
      watch_quiet = 1'b1;
      bus_start();
      put_byte({7'h05, 1'b0}, ack);
      chk(!ack, "R2 address 0x05 not acked", ack, 0);
      put_byte(8'h31, ack);
      put_byte(8'h02, ack);
      end_txn();
      watch_quiet = 1'b0;
      chk(!oe_seen, "R2 sda_oe stayed low for foreign address", oe_seen, 0);
      chk(cam_sel == 8'h01, "R2 foreign write ignored", cam_sel, 8'h01);

      // R8 camera select
      wr_txn(8'h31, 8'h02, 8'h00, 1, "R8 cam=2");
      chk(cam_sel == 8'h02, "R8 cam_sel after 2", cam_sel, 8'h02);
      wr_txn(8'h31, 8'h05, 8'h00, 1, "R8 cam=5 rejected");
      chk(cam_sel == 8'h02, "R8 cam_sel kept after 5", cam_sel, 8'h02);

      // R9 read with auto-increment into unused index
      rd_txn(8'h31, 2, "R9 read 0x31,0x32");

      // R3 write auto-increment: 0x30 (unused) then 0x31
      wr_txn(8'h30, 8'h99, 8'h01, 2, "R3 auto-increment");
      chk(cam_sel == 8'h01, "R3 second byte reached 0x31", cam_sel, 8'h01);

      // R5 lone second-register write
      wr_txn(8'h11, 8'h01, 8'h00, 1, "R5 lone 0x11");

      // R10 arm and read back, then R4 fire
      wr_txn(8'h70, 8'h01, 8'h00, 1, "R10 arm");
      rd_txn(8'h70, 1, "R10 0x70 reads 1 when armed");
      rd_txn(8'h11, 1, "R10 0x11 reads 0");
      wr_txn(8'h11, 8'h01, 8'h00, 1, "R4 ordered pair");
      chk(seen_pulses == 1, "R4 exactly one request", seen_pulses, 1);
      rd_txn(8'h70, 1, "R7 0x70 after request");
      rd_txn(8'h11, 1, "R7 0x11 after request");

      // R5 reverse order
      wr_txn(8'h11, 8'h01, 8'h00, 1, "R5 reverse step 1");
      wr_txn(8'h70, 8'h01, 8'h00, 1, "R5 reverse step 2");
      chk(seen_pulses == 1, "R5 reverse order no request", seen_pulses, 1);

      // R6 disarm by non-one value
      wr_txn(8'h70, 8'h03, 8'h00, 1, "R6 disarm");
      wr_txn(8'h11, 8'h01, 8'h00, 1, "R6 0x11 after disarm");
      chk(seen_pulses == 1, "R6 no request after disarm", seen_pulses, 1);

      // R4 again after re-arm
      wr_txn(8'h70, 8'h01, 8'h00, 1, "R4 re-arm");
      wr_txn(8'h11, 8'h01, 8'h00, 1, "R4 second fire");
      chk(seen_pulses == 2, "R4 second request", seen_pulses, 2);

      repeat (10) @(negedge clk);
      finish_run();
   end
endmodule